// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain lines, one facing a card and one facing a host, and repeats a logic 0 from whichever side pulls low first onto the other side. Both lines are sampled through two-flop synchronizers. The first side seen falling becomes the input side. The other side becomes the output side and is driven low once a programmable delay has passed. When the input side releases, the output side's drive is dropped and a strong pull-up enable is raised on that side for a programmable time. The block then goes back to watching both lines.

Each lane is one independent line pair. A width parameter replicates the lane, so one instance covers the data line and the two auxiliary lines. The pads are outside the block. Each side exposes a drive-low enable and a boost-high enable, and a pad is expected to behave as open drain wired-AND with any external driver.

Top module: `line_arbiter`

## Requirements
- R1: While rstN is low at a clock edge, every lane goes idle and all four enables of every lane (cardDriveLow, cardBoost, hostDriveLow, hostBoost) read 0 after that edge.
- R2: In an idle lane, a falling card line applied just after clock edge N makes the card side the input side. hostDriveLow rises at edge N+3+DELAY_CYC and is the only enable set in that lane.
- R3: In an idle lane, a falling host line applied just after edge N makes the host side the input side. cardDriveLow rises at edge N+3+DELAY_CYC.
- R4: If both lines of an idle lane fall in the same sample cycle, the card side is chosen as the input side.
- R5: While an input side is chosen and still low, falling edges on the output side have no effect. This covers edges caused by the lane's own drive and edges from an external driver.
- R6: When the input line returns high just after edge M while the output side is driven, that side's drive-low clears and its boost sets at edge M+3. The boost clears at edge M+3+BOOST_CYC, and the lane is then idle.
- R7: If the input line returns high before DELAY_CYC has elapsed, the lane returns to idle without setting any enable.
- R8: Drive-low and boost are never both set on the same side, and both sides are never driven low at once.
- R9: Lanes are independent. Activity on one lane leaves the enables of every other lane at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cardLine | input | LINES | Card-side pad levels, one bit per lane |
| hostLine | input | LINES | Host-side pad levels, one bit per lane |
| cardDriveLow | output | LINES | Pull card-side pad low |
| cardBoost | output | LINES | Strong pull-up enable on card-side pad |
| hostDriveLow | output | LINES | Pull host-side pad low |
| hostBoost | output | LINES | Strong pull-up enable on host-side pad |

## Verification
A wrong choice of input side shows up DELAY_CYC+3 cycles after the first falling edge, because the drive-low appears on the wrong side. Failing to mask the output side makes the lane flip direction or never release, and the boost pulse then comes late, comes on the wrong side or does not come at all. A mistimed counter moves the rise or fall of an enable by one or more cycles, so every enable change is compared against its exact expected cycle. Any change the bench did not predict is a failure, including any change on a lane that should be quiet.

// File: rtl/line_arb_pkg.sv
package line_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_BOOST = 2'd3
  } arbState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadDelay;
    logic loadBoost;
  } ctrlStrobe_t;

  // datapath -> control observations
  typedef struct packed {
    logic cardLow;
    logic hostLow;
    logic cardFall;
    logic hostFall;
    logic timerDone;
  } dpStatus_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import line_arb_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 13,
  parameter int unsigned BOOST_CYC = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cardLine,
  input  logic        hostLine,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);
  localparam int unsigned MAX_CYC = (DELAY_CYC > BOOST_CYC) ? DELAY_CYC : BOOST_CYC;
  localparam int unsigned CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] DELAY_LOAD = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] BOOST_LOAD = CW'(BOOST_CYC - 1);

  logic [1:0] cardSync, hostSync;
  logic cardPrev, hostPrev;
  logic [CW-1:0] timerCnt;

  // two-flop synchronizers plus one history flop per side; idle level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cardSync <= 2'b11;
      hostSync <= 2'b11;
      cardPrev <= 1'b1;
      hostPrev <= 1'b1;
    end else begin
      cardSync <= {cardSync[0], cardLine};
      hostSync <= {hostSync[0], hostLine};
      cardPrev <= cardSync[1];
      hostPrev <= hostSync[1];
    end
  end

  // shared down-counter for the repeat delay and the boost window
  always_ff @(posedge clk) begin
    if (!rstN)                 timerCnt <= '0;
    else if (strobe.loadDelay) timerCnt <= DELAY_LOAD;
    else if (strobe.loadBoost) timerCnt <= BOOST_LOAD;
    else if (timerCnt != '0)   timerCnt <= timerCnt - 1'b1;
  end

  always_comb begin
    status.cardLow   = ~cardSync[1];
    status.hostLow   = ~hostSync[1];
    status.cardFall  = cardPrev & ~cardSync[1];
    status.hostFall  = hostPrev & ~hostSync[1];
    status.timerDone = (timerCnt == '0);
  end

  // R2 R6: the counter never leaves its loaded range
  a_r2_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    timerCnt <= CW'(MAX_CYC - 1));

  // R6: a load is never issued for both windows at once
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadDelay && strobe.loadBoost));

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import line_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        cardDriveLow,
  output logic        cardBoost,
  output logic        hostDriveLow,
  output logic        hostBoost
);
  arbState_t state, stateNext;
  logic masterCard, masterCardNext;
  logic masterLow;

  assign masterLow = masterCard ? status.cardLow : status.hostLow;

  always_comb begin
    stateNext        = state;
    masterCardNext   = masterCard;
    strobe.loadDelay = 1'b0;
    strobe.loadBoost = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (status.cardFall) begin          // card wins a tie
          stateNext        = ST_WAIT;
          masterCardNext   = 1'b1;
          strobe.loadDelay = 1'b1;
        end else if (status.hostFall) begin
          stateNext        = ST_WAIT;
          masterCardNext   = 1'b0;
          strobe.loadDelay = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!masterLow)            stateNext = ST_IDLE;
        else if (status.timerDone) stateNext = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (!masterLow) begin
          stateNext        = ST_BOOST;
          strobe.loadBoost = 1'b1;
        end
      end
      ST_BOOST: begin
        if (status.timerDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      masterCard <= 1'b1;
    end else begin
      state      <= stateNext;
      masterCard <= masterCardNext;
    end
  end

  always_comb begin
    hostDriveLow = (state == ST_DRIVE) &&  masterCard;
    cardDriveLow = (state == ST_DRIVE) && !masterCard;
    hostBoost    = (state == ST_BOOST) &&  masterCard;
    cardBoost    = (state == ST_BOOST) && !masterCard;
  end

  // R1: reset leaves every enable off
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !(cardDriveLow || hostDriveLow || cardBoost || hostBoost));

  // R2 R3: a drive starts only when the delay counter has run out
  a_r2_drive_after_delay: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardDriveLow || hostDriveLow) |-> $past(status.timerDone));

  // R5: a held input keeps the drive in place whatever the output side does
  a_r5_hold_drive: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRIVE && masterLow) |=> (state == ST_DRIVE));

  // R6: a boost only follows a drive, and ends on counter expiry
  a_r6_boost_follows_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardBoost || hostBoost) |-> $past(cardDriveLow || hostDriveLow));
  a_r6_boost_ends_on_timer: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardBoost || hostBoost) |-> $past(status.timerDone));

  // R8: at most one of the four enables is active
  a_r8_exclusive_enables: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cardDriveLow, cardBoost, hostDriveLow, hostBoost}));

endmodule

// File: rtl/line_arbiter.sv
module line_arbiter
  import line_arb_pkg::*;
#(
  parameter int unsigned LINES     = 3,
  parameter int unsigned DELAY_CYC = 13,
  parameter int unsigned BOOST_CYC = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] cardLine,
  input  logic [LINES-1:0] hostLine,
  output logic [LINES-1:0] cardDriveLow,
  output logic [LINES-1:0] cardBoost,
  output logic [LINES-1:0] hostDriveLow,
  output logic [LINES-1:0] hostBoost
);
  for (genvar g = 0; g < LINES; g++) begin : g_lane
    ctrlStrobe_t strobe;
    dpStatus_t   status;

    arb_datapath #(
      .DELAY_CYC (DELAY_CYC),
      .BOOST_CYC (BOOST_CYC)
    ) i_dp (
      .clk      (clk),
      .rstN     (rstN),
      .cardLine (cardLine[g]),
      .hostLine (hostLine[g]),
      .strobe   (strobe),
      .status   (status)
    );

    arb_ctrl i_ctrl (
      .clk          (clk),
      .rstN         (rstN),
      .status       (status),
      .strobe       (strobe),
      .cardDriveLow (cardDriveLow[g]),
      .cardBoost    (cardBoost[g]),
      .hostDriveLow (hostDriveLow[g]),
      .hostBoost    (hostBoost[g])
    );
  end

endmodule

// File: tb/test_line_arbiter.sv
`timescale 1ns/1ps
module test_line_arbiter;
  localparam int LINES = 3;
  localparam int D = 4;
  localparam int B = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LINES-1:0] cardExt = '1, hostExt = '1;
  logic [LINES-1:0] cardPad, hostPad;
  logic [LINES-1:0] cardDriveLow, cardBoost, hostDriveLow, hostBoost;

  always #2 clk = ~clk;  // 250 MHz

  // open-drain pads: wired-AND of the external driver and the block's pull-down
  assign cardPad = cardExt & ~cardDriveLow;
  assign hostPad = hostExt & ~hostDriveLow;

  line_arbiter #(.LINES(LINES), .DELAY_CYC(D), .BOOST_CYC(B)) i_line_arbiter (
    .clk(clk), .rstN(rstN), .cardLine(cardPad), .hostLine(hostPad),
    .cardDriveLow(cardDriveLow), .cardBoost(cardBoost),
    .hostDriveLow(hostDriveLow), .hostBoost(hostBoost));

  typedef struct {
    int       lane;
    int       cyc;
    logic [3:0] val;   // {cardDriveLow, cardBoost, hostDriveLow, hostBoost}
    string    req;
  } event_t;

  event_t expQ[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  logic [3:0] prevOut [LINES];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] laneOut(int l);
    return {cardDriveLow[l], cardBoost[l], hostDriveLow[l], hostBoost[l]};
  endfunction

  task automatic push(int lane, int c, logic [3:0] v, string req);
    event_t e;
    e.lane = lane; e.cyc = c; e.val = v; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: every change of any lane's enables must match the queue front
  always @(negedge clk) begin
    if (monOn) begin
      for (int l = 0; l < LINES; l++) begin
        logic [3:0] cur;
        cur = laneOut(l);
        if (cur != prevOut[l]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R9", $sformatf("unexpected change lane %0d", l), int'(cur), int'(prevOut[l]));
          end else begin
            event_t e;
            e = expQ.pop_front();
            check(e.lane == l, e.req, "lane", l, e.lane);
            check(e.cyc == cyc, e.req, "cycle", cyc, e.cyc);
            check(e.val == cur, e.req, "enables", int'(cur), int'(e.val));
          end
          prevOut[l] = cur;
        end
      end
    end
  end

  // one repeat transaction: the chosen side falls, holds, then releases
  task automatic xfer(int lane, bit cardSide, bit both, int hold, string req);
    int c0, c1;
    @(negedge clk);
    c0 = cyc;
    if (cardSide || both) cardExt[lane] = 1'b0;
    if (!cardSide || both) hostExt[lane] = 1'b0;
    push(lane, c0 + 3 + D, cardSide ? 4'b0010 : 4'b1000, req);
    repeat (hold) @(negedge clk);
    c1 = cyc;
    if (cardSide || both) cardExt[lane] = 1'b1;
    if (!cardSide || both) hostExt[lane] = 1'b1;
    push(lane, c1 + 3, cardSide ? 4'b0001 : 4'b0100, {req, " R6"});
    push(lane, c1 + 3 + B, 4'b0000, {req, " R6"});
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int l = 0; l < LINES; l++) prevOut[l] = 4'b0000;
    repeat (5) @(negedge clk);
    check({cardDriveLow, cardBoost, hostDriveLow, hostBoost} == '0, "R1",
          "enables in reset", int'({cardDriveLow, cardBoost, hostDriveLow, hostBoost}), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (3) @(negedge clk);

    xfer(0, 1'b1, 1'b0, 12, "R2");        // card leads
    xfer(0, 1'b0, 1'b0, 12, "R3");        // host leads
    xfer(1, 1'b1, 1'b1, 12, "R4");        // tie, card must win

    // R5: external pulse on the driven output side changes nothing
    begin
      int c0, c1;
      @(negedge clk);
      c0 = cyc;
      cardExt[2] = 1'b0;
      push(2, c0 + 3 + D, 4'b0010, "R5");
      repeat (D + 6) @(negedge clk);
      hostExt[2] = 1'b0;
      check(cardDriveLow[0] == 1'b0 && hostDriveLow[1] == 1'b0, "R9",
            "other lanes idle", int'(cardDriveLow[0] | hostDriveLow[1]), 0);
      repeat (3) @(negedge clk);
      hostExt[2] = 1'b1;
      repeat (5) @(negedge clk);
      c1 = cyc;
      cardExt[2] = 1'b1;
      push(2, c1 + 3, 4'b0001, "R5 R6");
      push(2, c1 + 3 + B, 4'b0000, "R5 R6");
      repeat (20) @(negedge clk);
    end

    // R5: host falls while card is still being synchronized/delayed, and is
    // held past the card release (conflict); direction must not flip
    begin
      int c0, c1;
      @(negedge clk);
      c0 = cyc;
      cardExt[0] = 1'b0;
      push(0, c0 + 3 + D, 4'b0010, "R5");
      @(negedge clk);
      hostExt[0] = 1'b0;
      repeat (11) @(negedge clk);
      c1 = cyc;
      cardExt[0] = 1'b1;
      push(0, c1 + 3, 4'b0001, "R5 R6");
      push(0, c1 + 3 + B, 4'b0000, "R5 R6");
      repeat (15) @(negedge clk);
      hostExt[0] = 1'b1;
      repeat (15) @(negedge clk);
    end

    // R7: input released before the delay ends; nothing may be driven
    @(negedge clk);
    cardExt[1] = 1'b0;
    @(negedge clk);
    cardExt[1] = 1'b1;
    repeat (D + 10) @(negedge clk);
    check(laneOut(1) == 4'b0000, "R7", "enables after short pulse", int'(laneOut(1)), 0);
    check(expQ.size() == 0, "R7", "pending events", expQ.size(), 0);

    // R2 again after the cancelled pulse: lane 1 is back to idle
    xfer(1, 1'b1, 1'b0, 10, "R2");

    check(expQ.size() == 0, "R9", "events never seen", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule